// File: doc/BRIEF.md
# Banked SRAM Collision Arbiter

This block decides, cycle by cycle, which of four requesters may touch a banked on-chip data SRAM. The requesters are two core address generator ports, a store buffer and a combined DMA / cache fill-victim port. Each presents a valid flag and a byte address. Two requests are treated as a real conflict only when they land in the same physical sub-array. That is the case when they agree on bank, half bank, sub-bank and 32-bit word polarity. Every request that conflicts with nobody is granted at once, and conflicting requests are resolved by a fixed ranking.

The ranking places DMA last, so it can be starved. To bound that, the arbiter keeps a small amount of state for the DMA port. It counts consecutive cycles in which DMA was pending and refused. It also remembers whether a further DMA transfer was waiting behind the current one. Either condition lifts DMA to the top rank, and this is reported on a status output. Grants are purely combinational from the current requests. A refused requester simply holds its request and is judged afresh in the next cycle.

Top module: `sram_collision_arbiter`

## Requirements
- R1: A grant output is high only while the matching valid input is high.
- R2: The bank key of an address is bits 21:20, bit 16, bits 13:12 and bit 2. Two valid requests whose keys differ in any of these bits are both granted in the same cycle.
- R3: No two grants are high in one cycle for requests with equal bank keys.
- R4: Without promotion, the rank among requests with equal keys is address generator 0, then address generator 1, then store buffer, then DMA. Only the top-ranked one is granted.
- R5: A valid request that is refused always has a granted request with the same key in that cycle. No refusal is remembered beyond the cycle, except for the DMA state of R6 to R8.
- R6: If DMA is valid and refused for 17 consecutive cycles, it is promoted above every other requester in the next cycle and is granted there.
- R7: The DMA refusal count returns to zero in any cycle in which DMA is granted or not valid, and it saturates instead of wrapping.
- R8: If `dma_next_valid` is high in a cycle in which DMA is valid and refused, DMA is promoted from the next cycle until it is granted. A grant clears this condition.
- R9: `dma_promoted` is high exactly in the cycles in which DMA holds the top rank.
- R10: A synchronous active-high reset clears all promotion state, so `dma_promoted` is low in the first cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| dag0_valid | input | 1 | Address generator 0 request |
| dag0_addr | input | ADDR_W | Address generator 0 byte address |
| dag1_valid | input | 1 | Address generator 1 request |
| dag1_addr | input | ADDR_W | Address generator 1 byte address |
| stb_valid | input | 1 | Store buffer request |
| stb_addr | input | ADDR_W | Store buffer byte address |
| dma_valid | input | 1 | DMA / fill-victim request |
| dma_addr | input | ADDR_W | DMA / fill-victim byte address |
| dma_next_valid | input | 1 | A further DMA transfer waits behind the current one |
| dag0_gnt | output | 1 | Grant to address generator 0 |
| dag1_gnt | output | 1 | Grant to address generator 1 |
| stb_gnt | output | 1 | Grant to store buffer |
| dma_gnt | output | 1 | Grant to DMA / fill-victim port |
| dma_promoted | output | 1 | DMA currently holds the top rank |

## Verification
Grants depend only on the current requests and the registered DMA state, so they are due in the same cycle as the stimulus. The bench drives on the falling edge and samples one nanosecond later, before the next rising edge. Promotion is registered, so its effect appears one rising edge after the cycle that triggers it. The 17-cycle refusal run therefore produces a grant in the 18th pending cycle, and a queued transfer seen in one cycle produces a grant in the following one. The bench counts pending cycles itself and samples each of them at the same point.

// File: rtl/sram_arb_pkg.sv
package sram_arb_pkg;

    localparam int NREQ     = 4;
    localparam int IDX_DAG0 = 0;
    localparam int IDX_DAG1 = 1;
    localparam int IDX_STB  = 2;
    localparam int IDX_DMA  = 3;

    localparam int KEY_W = 6;
    typedef logic [KEY_W-1:0] bank_key_t;

    // Bits that select a physical sub-array: bank, half bank, sub-bank, word polarity.
    function automatic bank_key_t bank_key(input logic [31:0] a);
        return {a[21:20], a[16], a[13:12], a[2]};
    endfunction

    // Lower value wins. Promotion moves DMA ahead of all others.
    function automatic int rank_of(input int idx, input logic promo);
        if (promo) begin
            return (idx == IDX_DMA) ? 0 : idx + 1;
        end
        return idx;
    endfunction

endpackage

// File: rtl/sram_bank_match.sv
module sram_bank_match
    import sram_arb_pkg::*;
(
    input  logic      [NREQ-1:0]            req,
    input  bank_key_t [NREQ-1:0]            key,
    output logic      [NREQ-1:0][NREQ-1:0]  clash
);

    for (genvar i = 0; i < NREQ; i++) begin : g_row
        for (genvar j = 0; j < NREQ; j++) begin : g_col
            if (i == j) begin : g_self
                assign clash[i][j] = 1'b0;
            end else begin : g_pair
                assign clash[i][j] = req[i] && req[j] && (key[i] == key[j]);
            end
        end
    end

endmodule

// File: rtl/sram_grant_pick.sv
module sram_grant_pick
    import sram_arb_pkg::*;
(
    input  logic [NREQ-1:0]           req,
    input  logic [NREQ-1:0][NREQ-1:0] clash,
    input  logic                      promo,
    output logic [NREQ-1:0]           gnt
);

    for (genvar i = 0; i < NREQ; i++) begin : g_req
        logic beaten;

        always_comb begin
            beaten = 1'b0;
            for (int j = 0; j < NREQ; j++) begin
                if (clash[i][j] && (rank_of(j, promo) < rank_of(i, promo))) begin
                    beaten = 1'b1;
                end
            end
        end

        assign gnt[i] = req[i] & ~beaten;
    end

endmodule

// File: rtl/sram_dma_guard.sv
module sram_dma_guard #(
    parameter int STARVE_LIMIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic dma_valid,
    input  logic dma_next_valid,
    input  logic dma_gnt,
    output logic promo
);

    localparam int CNT_W = $clog2(STARVE_LIMIT + 2);
    localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(STARVE_LIMIT);
    localparam logic [CNT_W-1:0] SAT_V   = CNT_W'(STARVE_LIMIT + 1);

    typedef struct packed {
        logic [CNT_W-1:0] wait_cnt;
        logic             second;
    } guard_t;

    guard_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!dma_valid || dma_gnt) begin
            st_d.wait_cnt = '0;
            st_d.second   = 1'b0;
        end else begin
            if (st_q.wait_cnt != SAT_V) begin
                st_d.wait_cnt = st_q.wait_cnt + 1'b1;
            end
            st_d.second = st_q.second | dma_next_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign promo = (st_q.wait_cnt > LIMIT_V) || st_q.second;

endmodule

// File: rtl/sram_collision_arbiter.sv
module sram_collision_arbiter
    import sram_arb_pkg::*;
#(
    parameter int ADDR_W       = 32,
    parameter int STARVE_LIMIT = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dag0_valid,
    input  logic [ADDR_W-1:0] dag0_addr,
    input  logic              dag1_valid,
    input  logic [ADDR_W-1:0] dag1_addr,
    input  logic              stb_valid,
    input  logic [ADDR_W-1:0] stb_addr,
    input  logic              dma_valid,
    input  logic [ADDR_W-1:0] dma_addr,
    input  logic              dma_next_valid,
    output logic              dag0_gnt,
    output logic              dag1_gnt,
    output logic              stb_gnt,
    output logic              dma_gnt,
    output logic              dma_promoted
);

    logic      [NREQ-1:0]           req;
    bank_key_t [NREQ-1:0]           key;
    logic      [NREQ-1:0][NREQ-1:0] clash;
    logic      [NREQ-1:0]           gnt;
    logic                           promo;

    assign req[IDX_DAG0] = dag0_valid;
    assign req[IDX_DAG1] = dag1_valid;
    assign req[IDX_STB]  = stb_valid;
    assign req[IDX_DMA]  = dma_valid;

    assign key[IDX_DAG0] = bank_key(32'(dag0_addr));
    assign key[IDX_DAG1] = bank_key(32'(dag1_addr));
    assign key[IDX_STB]  = bank_key(32'(stb_addr));
    assign key[IDX_DMA]  = bank_key(32'(dma_addr));

    sram_bank_match i_match (
        .req   (req),
        .key   (key),
        .clash (clash)
    );

    sram_grant_pick i_pick (
        .req   (req),
        .clash (clash),
        .promo (promo),
        .gnt   (gnt)
    );

    sram_dma_guard #(
        .STARVE_LIMIT (STARVE_LIMIT)
    ) i_guard (
        .clk            (clk),
        .rst            (rst),
        .dma_valid      (dma_valid),
        .dma_next_valid (dma_next_valid),
        .dma_gnt        (gnt[IDX_DMA]),
        .promo          (promo)
    );

    assign dag0_gnt     = gnt[IDX_DAG0];
    assign dag1_gnt     = gnt[IDX_DAG1];
    assign stb_gnt      = gnt[IDX_STB];
    assign dma_gnt      = gnt[IDX_DMA];
    assign dma_promoted = promo;

endmodule

// File: rtl/sram_arb_checker.sv
module sram_arb_checker
    import sram_arb_pkg::*;
#(
    parameter int ADDR_W       = 32,
    parameter int STARVE_LIMIT = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              dag0_valid,
    input logic [ADDR_W-1:0] dag0_addr,
    input logic              dag1_valid,
    input logic [ADDR_W-1:0] dag1_addr,
    input logic              stb_valid,
    input logic [ADDR_W-1:0] stb_addr,
    input logic              dma_valid,
    input logic [ADDR_W-1:0] dma_addr,
    input logic              dma_next_valid,
    input logic              dag0_gnt,
    input logic              dag1_gnt,
    input logic              stb_gnt,
    input logic              dma_gnt,
    input logic              dma_promoted
);

    bank_key_t [NREQ-1:0] k;
    logic      [NREQ-1:0] v, g;
    logic                 dup_grant, orphan_deny;
    logic      [7:0]      run;

    assign k[0] = bank_key(32'(dag0_addr));
    assign k[1] = bank_key(32'(dag1_addr));
    assign k[2] = bank_key(32'(stb_addr));
    assign k[3] = bank_key(32'(dma_addr));
    assign v    = {dma_valid, stb_valid, dag1_valid, dag0_valid};
    assign g    = {dma_gnt, stb_gnt, dag1_gnt, dag0_gnt};

    always_comb begin
        dup_grant   = 1'b0;
        orphan_deny = 1'b0;
        for (int i = 0; i < NREQ; i++) begin
            logic covered;
            covered = 1'b0;
            for (int j = 0; j < NREQ; j++) begin
                if (i != j && g[i] && g[j] && k[i] == k[j]) dup_grant = 1'b1;
                if (i != j && g[j] && k[i] == k[j]) covered = 1'b1;
            end
            if (v[i] && !g[i] && !covered) orphan_deny = 1'b1;
        end
    end

    // Independent tally of consecutive refused DMA cycles.
    always_ff @(posedge clk) begin
        if (rst || !dma_valid || dma_gnt) begin
            run <= '0;
        end else if (run != 8'hFF) begin
            run <= run + 8'd1;
        end
    end

    assert_grant_needs_req_R1: assert property (@(posedge clk) disable iff (rst)
        (g & ~v) == '0);

    assert_one_per_bank_R3: assert property (@(posedge clk) disable iff (rst)
        !dup_grant);

    assert_dag0_top_R4: assert property (@(posedge clk) disable iff (rst)
        (dag0_valid && !dma_promoted) |-> dag0_gnt);

    assert_deny_has_winner_R5: assert property (@(posedge clk) disable iff (rst)
        !orphan_deny);

    assert_starve_promotes_R6: assert property (@(posedge clk) disable iff (rst)
        (dma_valid && int'(run) > STARVE_LIMIT) |-> (dma_gnt && dma_promoted));

    assert_second_promotes_R8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(dma_valid && !dma_gnt && dma_next_valid) && dma_valid)
            |-> (dma_promoted && dma_gnt));

    assert_promoted_wins_R9: assert property (@(posedge clk) disable iff (rst)
        (dma_promoted && dma_valid) |-> dma_gnt);

    assert_reset_clears_R10: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !dma_promoted);

endmodule

bind sram_collision_arbiter sram_arb_checker #(
    .ADDR_W       (ADDR_W),
    .STARVE_LIMIT (STARVE_LIMIT)
) i_chk (
    .clk            (clk),
    .rst            (rst),
    .dag0_valid     (dag0_valid),
    .dag0_addr      (dag0_addr),
    .dag1_valid     (dag1_valid),
    .dag1_addr      (dag1_addr),
    .stb_valid      (stb_valid),
    .stb_addr       (stb_addr),
    .dma_valid      (dma_valid),
    .dma_addr       (dma_addr),
    .dma_next_valid (dma_next_valid),
    .dag0_gnt       (dag0_gnt),
    .dag1_gnt       (dag1_gnt),
    .stb_gnt        (stb_gnt),
    .dma_gnt        (dma_gnt),
    .dma_promoted   (dma_promoted)
);

// File: tb/test_sram_collision_arbiter.sv
`timescale 1ns/1ps
module test_sram_collision_arbiter;

    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [3:0]    vld = '0;
    logic [AW-1:0] ad [4];
    logic          nxt = 1'b0;
    logic          dag0_gnt, dag1_gnt, stb_gnt, dma_gnt, dma_promoted;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    sram_collision_arbiter #(.ADDR_W(AW), .STARVE_LIMIT(16)) i_sram_collision_arbiter (
        .clk(clk), .rst(rst),
        .dag0_valid(vld[0]), .dag0_addr(ad[0]),
        .dag1_valid(vld[1]), .dag1_addr(ad[1]),
        .stb_valid(vld[2]),  .stb_addr(ad[2]),
        .dma_valid(vld[3]),  .dma_addr(ad[3]),
        .dma_next_valid(nxt),
        .dag0_gnt(dag0_gnt), .dag1_gnt(dag1_gnt), .stb_gnt(stb_gnt),
        .dma_gnt(dma_gnt), .dma_promoted(dma_promoted)
    );

    function automatic logic [5:0] keyof(input logic [31:0] a);
        return {a[21:20], a[16], a[13:12], a[2]};
    endfunction

    // Expected grants: a request loses only to a valid, better-ranked one with equal key.
    function automatic logic [3:0] expect_gnt(input logic [3:0] v, input logic promo);
        logic [3:0] e;
        for (int i = 0; i < 4; i++) begin
            int ri;
            ri = promo ? ((i == 3) ? 0 : i + 1) : i;
            e[i] = v[i];
            for (int j = 0; j < 4; j++) begin
                int rj;
                rj = promo ? ((j == 3) ? 0 : j + 1) : j;
                if (j != i && v[j] && rj < ri && keyof(ad[j]) == keyof(ad[i])) e[i] = 1'b0;
            end
        end
        return e;
    endfunction

    task automatic chk(input string req, input logic [4:0] act, input logic [4:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: {promoted,gnt}=%b expected %b", req, act, exp);
        end
    endtask

    function automatic logic [4:0] outs();
        return {dma_promoted, dma_gnt, stb_gnt, dag1_gnt, dag0_gnt};
    endfunction

    task automatic cycle(input logic [3:0] v, input logic n);
        @(negedge clk);
        vld = v;
        nxt = n;
        #1;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] base, filler;
        logic [31:0] flip [4];
        base   = 32'h0011_3004;
        filler = 32'h0040_C008;
        flip[0] = 32'h0000_0004;
        flip[1] = 32'h0000_1000;
        flip[2] = 32'h0001_0000;
        flip[3] = 32'h0020_0000;
        for (int i = 0; i < 4; i++) ad[i] = base;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R10 reset state", outs(), 5'b0);

        // R2 R4 R5 R1: all valid patterns times all address choices.
        for (int v = 0; v < 16; v++) begin
            for (int c = 0; c < 81; c++) begin
                int f, d;
                f = (v + c) % 4;
                d = c;
                for (int r = 0; r < 4; r++) begin
                    case (d % 3)
                        0: ad[r] = base;
                        1: ad[r] = base ^ filler;
                        default: ad[r] = base ^ flip[f];
                    endcase
                    d = d / 3;
                end
                cycle(v[3:0], 1'b0);
                chk("R1 R2 R3 R4 R5 sweep", outs(), {1'b0, expect_gnt(v[3:0], 1'b0)});
                cycle(4'b0000, 1'b0);
            end
        end

        // R6: DMA refused by dag0 on the same key; granted in the 18th pending cycle.
        for (int i = 0; i < 4; i++) ad[i] = base;
        for (int n = 1; n <= 18; n++) begin
            cycle(4'b1001, 1'b0);
            if (n == 18) chk("R6 R9 promoted after 17 refusals", outs(), 5'b11000);
            else         chk("R6 refused before limit", outs(), 5'b00001);
        end
        cycle(4'b1001, 1'b0);
        chk("R7 count cleared by grant", outs(), 5'b00001);
        cycle(4'b0001, 1'b0);

        // R7: a cycle without DMA request restarts the count.
        for (int n = 1; n <= 10; n++) cycle(4'b1001, 1'b0);
        cycle(4'b0001, 1'b0);
        for (int n = 1; n <= 18; n++) begin
            cycle(4'b1001, 1'b0);
            if (n == 17) chk("R7 restart: still refused at 17", outs(), 5'b00001);
            if (n == 18) chk("R7 restart: granted at 18", outs(), 5'b11000);
        end
        cycle(4'b0000, 1'b0);

        // R8: queued second transfer promotes DMA in the next cycle, then clears.
        cycle(4'b1101, 1'b1);
        chk("R8 queued cycle still refused", outs(), 5'b00001);
        cycle(4'b1101, 1'b0);
        chk("R8 promoted over all", outs(), 5'b11000);
        cycle(4'b1101, 1'b0);
        chk("R8 cleared after grant", outs(), 5'b00001);
        cycle(4'b0000, 1'b0);

        // R8 with different keys: promoted DMA does not block unrelated ports.
        ad[1] = base ^ flip[2];
        cycle(4'b1011, 1'b1);
        chk("R8 queued, dag1 independent", outs(), 5'b00011);
        cycle(4'b1011, 1'b0);
        chk("R2 R8 promoted, dag1 still served", outs(), 5'b11010);
        cycle(4'b0000, 1'b0);
        ad[1] = base;

        // R10: reset in the middle of a refusal run discards it.
        for (int n = 1; n <= 17; n++) cycle(4'b1001, 1'b0);
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R10 after reset", outs(), 5'b00001);
        cycle(4'b0000, 1'b0);
        chk("R10 idle", outs(), 5'b0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule